// File: doc/BRIEF.md
# Ordered Two-Half Message Read Buffer

This block holds one received 32-bit message word and presents it to a 16-bit CPU bus as two read-only halves. The receive logic deposits a complete word with a single-cycle load strobe. Software reads the most significant half at the lower address (address 0), then the least significant half at the higher address (address 1).

The required read order is what keeps the two halves from one word. A full-width read of the upper half also copies the lower half of the same stored word into a holding register. The next read of the lower half returns that copy. A word loaded between the two reads therefore cannot split the pair. The new word is seen only from the next upper-half read.

Read data comes from a register and is due one cycle after the read strobe. In every cycle that does not follow a valid read, the read data is zero.

Top module: `msg_rd_buf`

## Requirements
- R1: After reset, `rd_data_o` is 0, the stored word is 0 and the held lower half is 0.
- R2: A valid read at address 0 returns bits [31:16] of the stored word on `rd_data_o` in the following cycle.
- R3: A valid read at address 1 returns, in the following cycle, the lower half captured by the most recent valid read at address 0.
- R4: A word loaded between an address-0 read and the next address-1 read leaves the held lower half unchanged. The new word appears on the next address-0 read.
- R5: When `load_i` and a valid address-0 read occur in the same cycle, the read returns and snapshots the word stored before that cycle. The loaded word is stored for later reads.
- R6: A read is valid only when both bits of `be_i` are 1. A read with `be_i` other than 2'b11 returns 0 and leaves the held lower half unchanged.
- R7: A cycle with `wr_i` = 1 is a write, whatever the state of `rd_i`. A write returns 0 and changes neither the stored word nor the held lower half.
- R8: In a cycle after one with no valid read, `rd_data_o` is 0.
- R9: An address-1 read made before any address-0 read since reset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Stores `load_data_i` as the new message word |
| load_data_i | input | 32 | Received message word |
| rd_i | input | 1 | CPU read strobe |
| wr_i | input | 1 | CPU write strobe (ignored access) |
| addr_i | input | 1 | 0 = upper half, 1 = lower half |
| be_i | input | 2 | Byte enables; both must be set for a valid read |
| rd_data_o | output | 16 | Registered read data |

## Verification
Every read result is due exactly one clock after the strobe. A load changes the stored word from the next cycle on, so a read in the same cycle still sees the old word.

The bench drives inputs on the falling edge. It then advances a behavioural model of the stored word, the held half and the expected output by one step. At the next falling edge, one full cycle later, it compares `rd_data_o` with the model. Every cycle is checked this way, including idle cycles, partial-enable reads and writes, so a stray nonzero output is caught in the cycle it appears.

// File: rtl/msg_rd_buf_pkg.sv
package msg_rd_buf_pkg;
  typedef enum logic {
    HALF_HI_ADDR = 1'b0,
    HALF_LO_ADDR = 1'b1
  } half_addr_e;
endpackage

// File: rtl/msg_word_store.sv
module msg_word_store #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= load_data_i;
  end

  assign word_o = word_q;

  p_load_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> word_o == $past(load_data_i));
  p_no_load_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(word_o));
endmodule

// File: rtl/msg_rd_decode.sv
module msg_rd_decode
  import msg_rd_buf_pkg::*;
#(
  parameter int BE_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic            addr_i,
  input  logic [BE_W-1:0] be_i,
  output logic            up_rd_o,
  output logic            lo_rd_o
);
  logic full_acc;
  logic rd_ok;

  // partial-width and write cycles never qualify
  assign full_acc = &be_i;
  assign rd_ok    = rd_i & ~wr_i & full_acc;
  assign up_rd_o  = rd_ok & (half_addr_e'(addr_i) == HALF_HI_ADDR);
  assign lo_rd_o  = rd_ok & (half_addr_e'(addr_i) == HALF_LO_ADDR);

  p_one_access_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({up_rd_o, lo_rd_o}));
  p_write_no_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !(up_rd_o || lo_rd_o));
endmodule

// File: rtl/msg_snapshot.sv
module msg_snapshot #(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_rd_i,
  input  logic              lo_rd_i,
  input  logic [HALF_W-1:0] hi_half_i,
  input  logic [HALF_W-1:0] lo_half_i,
  output logic [HALF_W-1:0] rd_data_o
);
  logic [HALF_W-1:0] hold_q;
  logic [HALF_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      rd_q   <= '0;
    end else if (up_rd_i) begin
      rd_q   <= hi_half_i;
      hold_q <= lo_half_i;  // pair the low half with this upper read
    end else if (lo_rd_i) begin
      rd_q   <= hold_q;
    end else begin
      rd_q   <= '0;
    end
  end

  assign rd_data_o = rd_q;

  p_upper_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_rd_i |=> rd_data_o == $past(hi_half_i));
  p_lower_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_rd_i |=> rd_data_o == $past(hold_q));
  p_hold_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_rd_i |=> hold_q == $past(hold_q));
endmodule

// File: rtl/msg_rd_buf.sv
module msg_rd_buf #(
  parameter int WORD_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [WORD_W-1:0]   load_data_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic                addr_i,
  input  logic [WORD_W/16-1:0] be_i,
  output logic [WORD_W/2-1:0] rd_data_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int BE_W   = HALF_W / 8;

  logic [WORD_W-1:0] word;
  logic              up_rd;
  logic              lo_rd;

  msg_word_store #(.WORD_W(WORD_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .word_o      (word)
  );

  msg_rd_decode #(.BE_W(BE_W)) u_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .be_i    (be_i),
    .up_rd_o (up_rd),
    .lo_rd_o (lo_rd)
  );

  msg_snapshot #(.HALF_W(HALF_W)) u_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .up_rd_i   (up_rd),
    .lo_rd_i   (lo_rd),
    .hi_half_i (word[WORD_W-1:HALF_W]),
    .lo_half_i (word[HALF_W-1:0]),
    .rd_data_o (rd_data_o)
  );

  p_partial_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !(&be_i)) |=> rd_data_o == '0);
  p_write_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rd_data_o == '0);
  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rd_data_o == '0);
endmodule

// File: tb/tb_msg_rd_buf.sv
module tb_msg_rd_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] load_data = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic        addr = 1'b0;
  logic [1:0]  be = 2'b00;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_word = '0;
  logic [15:0] m_hold = '0;
  logic [15:0] m_exp  = '0;

  always #5 clk = ~clk;

  msg_rd_buf dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .load_i      (load),
    .load_data_i (load_data),
    .rd_i        (rd),
    .wr_i        (wr),
    .addr_i      (addr),
    .be_i        (be),
    .rd_data_o   (rd_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data_o actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, step model, compare one clock later
  task automatic cyc(input string req, input logic ld, input logic [31:0] ld_d,
                     input logic r, input logic w, input logic a, input logic [1:0] b);
    load = ld; load_data = ld_d; rd = r; wr = w; addr = a; be = b;
    if (r && !w && b == 2'b11 && a == 1'b0) begin
      m_exp  = m_word[31:16];
      m_hold = m_word[15:0];
    end else if (r && !w && b == 2'b11 && a == 1'b1) begin
      m_exp = m_hold;
    end else begin
      m_exp = '0;
    end
    if (ld) m_word = ld_d;
    @(posedge clk);
    @(negedge clk);
    check(req, rd_data, m_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rd_data, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rd_data, 16'h0);

    // R9: lower before any upper read
    cyc("R9", 0, 0, 1, 0, 1, 2'b11);

    // R2 / R3 basic ordered pair
    cyc("R8", 1, 32'h1234_5678, 0, 0, 0, 2'b00);
    cyc("R2", 0, 0, 1, 0, 0, 2'b11);
    cyc("R3", 0, 0, 1, 0, 1, 2'b11);

    // R4: load between the two reads
    cyc("R2", 0, 0, 1, 0, 0, 2'b11);
    cyc("R4", 1, 32'hAAAA_BBBB, 0, 0, 0, 2'b00);
    cyc("R4", 0, 0, 1, 0, 1, 2'b11);
    cyc("R4", 0, 0, 1, 0, 0, 2'b11);
    cyc("R4", 0, 0, 1, 0, 1, 2'b11);

    // R5: load coincides with upper read
    cyc("R5", 1, 32'hCCCC_DDDD, 1, 0, 0, 2'b11);
    cyc("R5", 0, 0, 1, 0, 1, 2'b11);
    cyc("R5", 0, 0, 1, 0, 0, 2'b11);
    cyc("R5", 0, 0, 1, 0, 1, 2'b11);

    // R6: partial byte enables
    cyc("R8", 1, 32'hEEEE_FFFF, 0, 0, 0, 2'b00);
    cyc("R6", 0, 0, 1, 0, 0, 2'b01);
    cyc("R6", 0, 0, 1, 0, 0, 2'b10);
    cyc("R6", 0, 0, 1, 0, 1, 2'b00);
    cyc("R6", 0, 0, 1, 0, 1, 2'b11);

    // R7: writes ignored
    cyc("R7", 0, 0, 0, 1, 0, 2'b11);
    cyc("R7", 0, 0, 1, 1, 0, 2'b11);
    cyc("R7", 0, 0, 1, 1, 1, 2'b11);
    cyc("R7", 0, 0, 1, 0, 1, 2'b11);
    cyc("R7", 0, 0, 1, 0, 0, 2'b11);

    // R8: idle cycles, byte enables alone do nothing
    cyc("R8", 0, 0, 0, 0, 0, 2'b11);
    cyc("R8", 0, 0, 0, 0, 1, 2'b11);

    // mixed patterns
    for (int i = 0; i < 16; i++) begin
      logic [31:0] v;
      v = 32'h9E37_79B9 * (i + 1);
      cyc("R4", 1, v, 0, 0, 0, 2'b00);
      cyc("R2", (i % 3) == 0, ~v, 1, 0, 0, 2'b11);
      cyc("R3", (i % 2) == 0, v ^ 32'h5A5A_A5A5, 1, 0, 1, 2'b11);
      cyc("R6", 0, 0, 1, 0, i[0], 2'b01);
    end

    cyc("R8", 0, 0, 0, 0, 0, 2'b00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule